// File: doc/BRIEF.md
# Virtualized Instruction Trap Classifier

This block sits in the exception stage of a core with hypervisor support. For each instruction it is offered, it looks at the instruction's decoded class, the CSR address (for CSR accesses), the current privilege level and whether the hart runs a guest (V). It also looks at three hypervisor trap-control bits and at the two counter-enable masks. From these it gives one of three verdicts: no trap, illegal-instruction exception (cause 2) or virtual-instruction exception (cause 22).

Cases that a hypervisor would normally emulate are sent to the virtual-instruction cause. Cases that need machine-level handling, or that are plainly invalid, take the illegal-instruction cause. In both cases the trap value is the faulting instruction word. A guest WFI with the WFI trap control set is not classified at once. It arms a countdown of `WFI_BOUND` cycles: a pending interrupt ends the wait without a trap, and expiry raises a virtual-instruction exception.

Results are registered: a verdict shows on the outputs one cycle after the instruction is offered. While a timed WFI is pending, `instValid` is ignored.

Top module: `vtrap_classifier`

## Requirements
- R1: When V is 0, or the privilege is machine (privMode 2'b11), cause 22 is never produced. Every faulting case then reports cause 2.
- R2: A counter CSR access (address 0xC00..0xC1F, bit index addr[4:0]) from a non-machine level raises cause 2 when the mcounteren bit is 0, whatever hcounteren holds. With V=1, mcounteren bit 1 and hcounteren bit 0, it raises cause 22. With both bits 1 there is no trap.
- R3: HLV, HLVX or HSV (class 3) raises cause 22 whenever V=1, in guest supervisor or guest user mode. With V=0 it raises cause 2 in user mode and no trap in supervisor mode.
- R4: HFENCE (class 4), or an access to a hypervisor-level CSR (addr[9:8]=2'b10, covering both hypervisor and guest-supervisor CSRs), raises cause 22 in guest supervisor mode and cause 2 from any user mode (privMode 2'b00). Host supervisor mode takes no trap.
- R5: SRET (class 5) in guest supervisor mode raises cause 22 when the SRET trap bit is 1 and takes no trap when it is 0. From user mode it raises cause 2.
- R6: SFENCE (class 6), or an access to the address-translation CSR 0x180, raises cause 22 in guest supervisor mode when the VM trap bit is 1 and takes no trap when it is 0. From user mode it raises cause 2.
- R7: For any trap, trapValue equals the faulting instruction bits, for both causes. An instruction that does not fault leaves trapValid low.
- R8: A WFI (class 7) with V=1 and the WFI trap bit set raises wfiWaiting for WFI_BOUND cycles. If no interrupt arrives, cause 22 appears with trapValue holding the WFI's bits, WFI_BOUND+1 cycles after the WFI was offered.
- R9: A pending interrupt during the wait clears wfiWaiting on the next edge, and no trap follows. A WFI with V=0 or with the WFI trap bit clear never traps.
- R10: A verdict is visible one cycle after instValid. While wfiWaiting is high, offered instructions are ignored and produce no trap.
- R11: Decoder-illegal instructions (class 1), and machine-level CSRs (addr[9:8]=2'b11) accessed below machine level, always raise cause 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| instValid | input | 1 | Instruction offered this cycle |
| instClass | input | 4 | 0 other, 1 illegal, 2 CSR, 3 HLV/HLVX/HSV, 4 HFENCE, 5 SRET, 6 SFENCE, 7 WFI |
| csrAddr | input | 12 | CSR address for class 2 |
| instBits | input | ILEN | Instruction word |
| virtMode | input | 1 | V: hart runs a guest |
| privMode | input | 2 | 00 user, 01 supervisor, 11 machine |
| trapSret | input | 1 | Guest SRET trap control |
| trapVm | input | 1 | Guest SFENCE/satp trap control |
| trapWfi | input | 1 | Guest WFI trap control |
| hcounteren | input | 32 | Hypervisor counter-enable mask |
| mcounteren | input | 32 | Machine counter-enable mask |
| irqPending | input | 1 | Interrupt pending, ends a WFI wait |
| trapValid | output | 1 | Trap reported this cycle |
| trapCause | output | CAUSE_W | 2 or 22 |
| trapValue | output | ILEN | Faulting instruction bits |
| wfiWaiting | output | 1 | Timed guest WFI in progress |

## Verification
The bench builds the block with WFI_BOUND set to 6, so that both the expiry trap and an interrupt arriving mid-wait can be reached in a few cycles. The other parameters keep their defaults. With this short bound the bench can also offer a second instruction during the wait, and check that it is dropped without a trap.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;
  typedef enum logic [3:0] {
    CLS_OTHER   = 4'd0,
    CLS_ILLEGAL = 4'd1,
    CLS_CSR     = 4'd2,
    CLS_HLSV    = 4'd3,
    CLS_HFENCE  = 4'd4,
    CLS_SRET    = 4'd5,
    CLS_SFENCE  = 4'd6,
    CLS_WFI     = 4'd7
  } inst_class_e;

  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_ILL  = 2'd1,
    VERD_VIRT = 2'd2
  } verdict_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [11:0] ADDR_SATP = 12'h180;
  localparam logic [6:0]  CNT_BASE  = 7'h60;  // 0xC00..0xC1F

  localparam int unsigned CAUSE_ILL  = 2;
  localparam int unsigned CAUSE_VIRT = 22;

  typedef struct packed {
    logic load;      // report a trap next cycle
    logic isVirt;    // virtual cause, else illegal
    logic useHeld;   // take value from held WFI bits
    logic capture;   // hold current instruction bits
  } ctrl_strobe_t;
endpackage

// File: rtl/vtrap_ctrl.sv
module vtrap_ctrl
  import vtrap_pkg::*;
#(
  parameter int unsigned WFI_BOUND = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instValid,
  input  inst_class_e  instClass,
  input  logic [11:0]  csrAddr,
  input  logic         virtMode,
  input  logic [1:0]   privMode,
  input  logic         trapSret,
  input  logic         trapVm,
  input  logic         trapWfi,
  input  logic [31:0]  hcounteren,
  input  logic [31:0]  mcounteren,
  input  logic         irqPending,
  output ctrl_strobe_t stb,
  output logic         waiting
);
  localparam int unsigned CNT_W = $clog2(WFI_BOUND + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WFI_BOUND - 1);

  logic [CNT_W-1:0] waitCount;
  verdict_e verdict;
  logic startWfi, accept, timeout;
  logic isM, isU, effV, isCounter;
  logic [4:0] cntIdx;

  assign isM = (privMode == PRIV_M);
  assign isU = (privMode == PRIV_U);
  assign effV = virtMode && !isM;
  assign isCounter = (csrAddr[11:5] == CNT_BASE);
  assign cntIdx = csrAddr[4:0];
  assign accept = instValid && !waiting;
  assign timeout = waiting && !irqPending && (waitCount == LAST);

  always_comb begin
    verdict = VERD_NONE;
    startWfi = 1'b0;
    unique case (instClass)
      CLS_ILLEGAL: verdict = VERD_ILL;
      CLS_CSR: begin
        if (!isM) begin
          if (csrAddr[9:8] == 2'b11) verdict = VERD_ILL;
          else if (isCounter) begin
            if (!mcounteren[cntIdx]) verdict = VERD_ILL;
            else if (effV && !hcounteren[cntIdx]) verdict = VERD_VIRT;
          end else if (csrAddr[9:8] == 2'b10) begin
            if (isU) verdict = VERD_ILL;
            else if (effV) verdict = VERD_VIRT;
          end else if (csrAddr[9:8] == 2'b01) begin
            if (isU) verdict = VERD_ILL;
            else if (effV && trapVm && csrAddr == ADDR_SATP) verdict = VERD_VIRT;
          end
        end
      end
      CLS_HLSV: begin
        if (effV) verdict = VERD_VIRT;
        else if (isU) verdict = VERD_ILL;
      end
      CLS_HFENCE: begin
        if (isU) verdict = VERD_ILL;
        else if (effV) verdict = VERD_VIRT;
      end
      CLS_SRET: begin
        if (isU) verdict = VERD_ILL;
        else if (effV && trapSret) verdict = VERD_VIRT;
      end
      CLS_SFENCE: begin
        if (isU) verdict = VERD_ILL;
        else if (effV && trapVm) verdict = VERD_VIRT;
      end
      CLS_WFI: startWfi = effV && trapWfi;
      default: verdict = VERD_NONE;
    endcase
  end

  always_comb begin
    stb.load    = (accept && verdict != VERD_NONE) || timeout;
    stb.isVirt  = timeout || (accept && verdict == VERD_VIRT);
    stb.useHeld = timeout;
    stb.capture = accept && startWfi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      waitCount <= '0;
    end else if (stb.capture) begin
      waiting <= 1'b1;
      waitCount <= '0;
    end else if (waiting) begin
      if (irqPending || timeout) waiting <= 1'b0;
      else waitCount <= waitCount + 1'b1;
    end
  end

  // R1: no virtual verdict is accepted from a host or machine context
  p_no_virt_host_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !effV) |-> !stb.isVirt);
  // R8: the wait counter stays inside the bound
  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (waitCount <= LAST));
  // R9: an interrupt ends the wait on the next edge
  p_irq_ends_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && irqPending) |=> !waiting);
endmodule

// File: rtl/vtrap_dp.sv
module vtrap_dp
  import vtrap_pkg::*;
#(
  parameter int unsigned ILEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_strobe_t       stb,
  input  logic [ILEN-1:0]    instBits,
  output logic               trapValid,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [ILEN-1:0]    trapValue
);
  logic [ILEN-1:0] heldBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldBits  <= '0;
      trapValid <= 1'b0;
      trapCause <= '0;
      trapValue <= '0;
    end else begin
      if (stb.capture) heldBits <= instBits;
      trapValid <= stb.load;
      if (stb.load) begin
        trapCause <= stb.isVirt ? CAUSE_W'(CAUSE_VIRT) : CAUSE_W'(CAUSE_ILL);
        trapValue <= stb.useHeld ? heldBits : instBits;
      end else begin
        trapCause <= '0;
        trapValue <= '0;
      end
    end
  end

  // R10: a load strobe is reported on the following cycle
  p_load_reported_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> trapValid);
  // R7: only the two defined causes ever leave the block
  p_cause_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trapValid |-> (trapCause == CAUSE_W'(CAUSE_ILL) || trapCause == CAUSE_W'(CAUSE_VIRT)));
endmodule

// File: rtl/vtrap_classifier.sv
module vtrap_classifier
  import vtrap_pkg::*;
#(
  parameter int unsigned ILEN      = 32,
  parameter int unsigned CAUSE_W   = 6,
  parameter int unsigned WFI_BOUND = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instValid,
  input  logic [3:0]         instClass,
  input  logic [11:0]        csrAddr,
  input  logic [ILEN-1:0]    instBits,
  input  logic               virtMode,
  input  logic [1:0]         privMode,
  input  logic               trapSret,
  input  logic               trapVm,
  input  logic               trapWfi,
  input  logic [31:0]        hcounteren,
  input  logic [31:0]        mcounteren,
  input  logic               irqPending,
  output logic               trapValid,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [ILEN-1:0]    trapValue,
  output logic               wfiWaiting
);
  ctrl_strobe_t stb;

  vtrap_ctrl #(.WFI_BOUND(WFI_BOUND)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid),
    .instClass(inst_class_e'(instClass)), .csrAddr(csrAddr),
    .virtMode(virtMode), .privMode(privMode), .trapSret(trapSret),
    .trapVm(trapVm), .trapWfi(trapWfi), .hcounteren(hcounteren),
    .mcounteren(mcounteren), .irqPending(irqPending),
    .stb(stb), .waiting(wfiWaiting)
  );

  vtrap_dp #(.ILEN(ILEN), .CAUSE_W(CAUSE_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .instBits(instBits),
    .trapValid(trapValid), .trapCause(trapCause), .trapValue(trapValue)
  );
endmodule

// File: tb/test_vtrap_classifier.sv
module test_vtrap_classifier;
  localparam int BOUND = 6;
  localparam int EXP_NONE = 0, EXP_ILL = 1, EXP_VIRT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instValid = 1'b0;
  logic [3:0] instClass = '0;
  logic [11:0] csrAddr = '0;
  logic [31:0] instBits = '0;
  logic virtMode = 1'b0;
  logic [1:0] privMode = 2'b01;
  logic trapSret = 1'b0, trapVm = 1'b0, trapWfi = 1'b0;
  logic [31:0] hcounteren = '0, mcounteren = '0;
  logic irqPending = 1'b0;
  logic trapValid, wfiWaiting;
  logic [5:0] trapCause;
  logic [31:0] trapValue;

  typedef struct {
    int due;
    int kind;
    logic [31:0] bits;
    string tag;
  } exp_t;
  exp_t sb[$];
  int cyc = 0, vectors = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vtrap_classifier #(.WFI_BOUND(BOUND)) i_vtrap_classifier (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .instClass(instClass),
    .csrAddr(csrAddr), .instBits(instBits), .virtMode(virtMode),
    .privMode(privMode), .trapSret(trapSret), .trapVm(trapVm),
    .trapWfi(trapWfi), .hcounteren(hcounteren), .mcounteren(mcounteren),
    .irqPending(irqPending), .trapValid(trapValid), .trapCause(trapCause),
    .trapValue(trapValue), .wfiWaiting(wfiWaiting)
  );

  // monitor: pops the item due this cycle and compares
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        logic eV;
        int eC;
        e = sb.pop_front();
        eV = (e.kind != EXP_NONE);
        eC = (e.kind == EXP_VIRT) ? 22 : 2;
        vectors++;
        if (trapValid !== eV || (eV && (trapCause != 6'(eC) || trapValue !== e.bits))) begin
          errors++;
          $display("FAIL %s: valid=%0b cause=%0d value=%h, expected valid=%0b cause=%0d value=%h",
                   e.tag, trapValid, trapCause, trapValue, eV, eV ? eC : 0, e.bits);
        end
      end else if (trapValid) begin
        vectors++; errors++;
        $display("FAIL R10 unexpected trap: cause=%0d value=%h, expected none", trapCause, trapValue);
      end
    end
  end

  task automatic apply(input int cls, input logic [11:0] addr, input logic v,
                       input logic [1:0] pm, input int kind, input string tag);
    @(negedge clk);
    instValid = 1'b1; instClass = 4'(cls); csrAddr = addr;
    virtMode = v; privMode = pm;
    instBits = $urandom;
    sb.push_back('{due: cyc + 1, kind: kind, bits: instBits, tag: tag});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    instValid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic direct(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b, expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (trapValid !== 1'b0 || wfiWaiting !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: valid=%0b waiting=%0b, expected 0 0", trapValid, wfiWaiting);
    end
    rst_n = 1'b1;

    // R2 counters: bit 3 (0xC03)
    mcounteren = 32'h0000_0008; hcounteren = 32'h0;
    apply(2, 12'hC03, 1, 2'b01, EXP_VIRT, "R2 hcounteren clear guest");
    apply(2, 12'hC03, 1, 2'b00, EXP_VIRT, "R2 hcounteren clear guest user");
    apply(2, 12'hC03, 0, 2'b01, EXP_NONE, "R2 host counter allowed");
    apply(2, 12'hC04, 1, 2'b01, EXP_ILL, "R2 mcounteren clear");
    hcounteren = 32'hFFFF_FFFF;
    apply(2, 12'hC04, 1, 2'b01, EXP_ILL, "R2 mcounteren clear overrides");
    apply(2, 12'hC03, 1, 2'b01, EXP_NONE, "R2 both enabled");
    apply(2, 12'hC04, 0, 2'b00, EXP_ILL, "R1 host counter blocked");
    // R3
    apply(3, 12'h0, 1, 2'b01, EXP_VIRT, "R3 HLV guest sup");
    apply(3, 12'h0, 1, 2'b00, EXP_VIRT, "R3 HLV guest user");
    apply(3, 12'h0, 0, 2'b00, EXP_ILL, "R3 HLV host user");
    apply(3, 12'h0, 0, 2'b01, EXP_NONE, "R3 HLV host sup");
    // R4
    apply(4, 12'h0, 1, 2'b01, EXP_VIRT, "R4 HFENCE guest sup");
    apply(4, 12'h0, 1, 2'b00, EXP_ILL, "R4 HFENCE guest user");
    apply(2, 12'h600, 1, 2'b01, EXP_VIRT, "R4 hyp CSR guest sup");
    apply(2, 12'h200, 1, 2'b01, EXP_VIRT, "R4 guest-sup CSR guest sup");
    apply(2, 12'h600, 0, 2'b01, EXP_NONE, "R4 hyp CSR host sup");
    // R5
    trapSret = 1'b1;
    apply(5, 12'h0, 1, 2'b01, EXP_VIRT, "R5 SRET trapped");
    apply(5, 12'h0, 0, 2'b01, EXP_NONE, "R1 SRET host");
    trapSret = 1'b0;
    apply(5, 12'h0, 1, 2'b01, EXP_NONE, "R5 SRET untrapped");
    apply(5, 12'h0, 1, 2'b00, EXP_ILL, "R5 SRET guest user");
    // R6
    trapVm = 1'b1;
    apply(6, 12'h0, 1, 2'b01, EXP_VIRT, "R6 SFENCE trapped");
    apply(2, 12'h180, 1, 2'b01, EXP_VIRT, "R6 satp trapped");
    apply(2, 12'h180, 0, 2'b01, EXP_NONE, "R1 satp host");
    trapVm = 1'b0;
    apply(6, 12'h0, 1, 2'b01, EXP_NONE, "R6 SFENCE untrapped");
    apply(2, 12'h180, 1, 2'b00, EXP_ILL, "R6 satp guest user");
    // R11 / R1 / R7
    apply(1, 12'h0, 1, 2'b01, EXP_ILL, "R11 decoder illegal");
    apply(2, 12'h300, 1, 2'b01, EXP_ILL, "R11 machine CSR guest");
    apply(2, 12'h300, 2'b11, 2'b11, EXP_NONE, "R1 machine CSR in M");
    apply(3, 12'h0, 1, 2'b11, EXP_NONE, "R1 V ignored in M");
    apply(0, 12'h0, 1, 2'b01, EXP_NONE, "R7 ordinary no trap");
    idle(2);

    // R8 timeout, with an ignored instruction during the wait (R10)
    trapWfi = 1'b1;
    begin
      int c0;
      logic [31:0] wb;
      apply(7, 12'h0, 1, 2'b01, EXP_NONE, "R8 WFI start");
      c0 = cyc; wb = instBits;
      sb.push_back('{due: c0 + 1 + BOUND, kind: EXP_VIRT, bits: wb, tag: "R8 WFI timeout"});
      @(negedge clk); instValid = 1'b0;
      direct(wfiWaiting, 1'b1, "R8 waiting raised");
      apply(1, 12'h0, 1, 2'b01, EXP_NONE, "R10 ignored while waiting");
      idle(BOUND + 2);
      direct(wfiWaiting, 1'b0, "R8 waiting cleared after timeout");
    end

    // R9 interrupt ends wait
    begin
      int c0;
      apply(7, 12'h0, 1, 2'b01, EXP_NONE, "R9 WFI start");
      c0 = cyc;
      sb.push_back('{due: c0 + 1 + BOUND, kind: EXP_NONE, bits: '0, tag: "R9 no trap after irq"});
      idle(2);
      irqPending = 1'b1;
      @(negedge clk); irqPending = 1'b0;
      direct(wfiWaiting, 1'b0, "R9 irq cleared waiting");
      idle(BOUND + 2);
    end

    // R9 WFI without trap control or host
    trapWfi = 1'b0;
    apply(7, 12'h0, 1, 2'b01, EXP_NONE, "R9 WFI control clear");
    idle(1);
    direct(wfiWaiting, 1'b0, "R9 no wait when control clear");
    trapWfi = 1'b1;
    apply(7, 12'h0, 0, 2'b01, EXP_NONE, "R9 WFI host");
    idle(1);
    direct(wfiWaiting, 1'b0, "R9 no wait on host");
    idle(BOUND + 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule